// File: doc/BRIEF.md
# Serial ADC Host Controller with Power Sequencing

This block is the host side of a three-wire link to a 12-bit (or 10-bit) successive-approximation converter. It drives an active-low chip-select and a serial clock made from the system clock by a divider, and shifts in the 16-bit frame that the converter sends back. The converter has no control register. Its power state follows only from how many serial-clock falling edges pass before chip-select rises again. The controller uses that rule to move the converter between normal operation, partial power-down and full power-down.

A user issues one command at a time on a small command port while `busy` is low. The commands are: convert, enter partial power-down, enter full power-down, wake, and three power-on initialisation sequences. A convert returns the result with a one-cycle valid strobe. The other commands run one, two or three dummy frames whose data is thrown away. The controller keeps its own view of the converter's power mode on `pwr_mode`. It refuses any command that makes no sense in that mode. After each frame it enforces a quiet gap. After a wake from full power-down it also waits a power-up interval.

Top module: `adc_pwr_host`

## Requirements
- R1: After reset, `cs_n` and `sclk` are high, `busy` and `result_valid` are low, and `pwr_mode` is 3 (unknown).
- R2: A convert frame (cmd_op 0) holds `cs_n` low for exactly 16 `sclk` falling edges. It samples `sdata` on each rising edge and takes the bits seen after falling edges 2 to RES_BITS+1, MSB first, as `result`. `result_valid` pulses for one cycle in the cycle `cs_n` rises.
- R3: `sclk` is high whenever `cs_n` is high. While `cs_n` is low, each `sclk` level, the first and the last included, lasts exactly CLK_DIV system clocks.
- R4: Enter partial power-down (cmd_op 1) is accepted only when `pwr_mode` is 0 (normal). It raises `cs_n` after PART_EDGES falling edges and sets `pwr_mode` to 1 (partial).
- R5: Enter full power-down (cmd_op 2) is accepted only when `pwr_mode` is 1. It raises `cs_n` after FULL_EDGES falling edges and sets `pwr_mode` to 2 (full). In any other mode it is ignored: `cs_n` stays high, `busy` stays low and `pwr_mode` is unchanged.
- R6: Wake (cmd_op 3) is accepted when `pwr_mode` is not 0. It runs one 16-edge dummy frame with no `result_valid` and sets `pwr_mode` to 0.
- R7: A wake issued in mode 2 keeps `busy` high for at least PWRUP_CLKS system clocks, counted from the fall of `cs_n`.
- R8: Between the rise of `cs_n` and its next fall, `cs_n` stays high for at least QUIET_CLKS clocks. `busy` stays high until the quiet gap after the last frame of a command has ended.
- R9: Initialisation is accepted in any mode and runs these frames in order:
  - cmd_op 4 runs one 16-edge frame and ends in mode 0.
  - cmd_op 5 adds a PART_EDGES frame and ends in mode 1.
  - cmd_op 6 adds a further FULL_EDGES frame and ends in mode 2.
- R10: Convert is accepted only in mode 0. Every command is ignored while `busy` is high, and cmd_op 7 is always ignored.
- R11: With RES_BITS = 10 the frame is still 16 edges long, and `result` holds the 10 bits taken after falling edges 2 to 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe, taken when `busy` is low |
| cmd_op | input | 3 | Command code (0 convert, 1 partial, 2 full, 3 wake, 4/5/6 init to normal/partial/full) |
| busy | output | 1 | Command in progress |
| cs_n | output | 1 | Converter chip-select, active low |
| sclk | output | 1 | Serial clock to the converter |
| sdata | input | 1 | Serial data from the converter |
| result | output | RES_BITS | Last conversion result |
| result_valid | output | 1 | One-cycle strobe when `result` is new |
| pwr_mode | output | 2 | Believed converter mode (0 normal, 1 partial, 2 full, 3 unknown) |

## Verification
The bench runs a behavioural converter model that counts falling edges and changes its own power state at each rise of chip-select. Against that model it targets the points where one edge too many or too few would silently push the converter into the wrong mode: a partial or full power-down frame, and the second and third frames of an initialisation. A design off by one edge there would end with `pwr_mode` disagreeing with the model, or with the wrong edge count in the last frame. The bench also sends full power-down from normal mode, converts from a powered-down mode, and commands during a busy frame. A design that accepted any of these would show chip-select activity or a changed mode. Random commands with random data check that the sampling edge is correct, at both resolutions. They also check that the quiet gap and the power-up wait after a wake from full power-down are never cut short.

// File: rtl/adc_pwr_host.sv
module adc_pwr_host #(
  parameter int RES_BITS   = 12,
  parameter int CLK_DIV    = 4,
  parameter int PART_EDGES = 4,
  parameter int FULL_EDGES = 2,
  parameter int QUIET_CLKS = 8,
  parameter int PWRUP_CLKS = 200
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmd_valid,
  input  logic [2:0]          cmd_op,
  output logic                busy,
  output logic                cs_n,
  output logic                sclk,
  input  logic                sdata,
  output logic [RES_BITS-1:0] result,
  output logic                result_valid,
  output logic [1:0]          pwr_mode
);
  localparam int DW = $clog2(CLK_DIV + 1);
  localparam int QW = $clog2(QUIET_CLKS + 1);
  localparam int PW = $clog2(PWRUP_CLKS + 1);
  localparam logic [4:0] FRAME_LEN = 5'd16;

  localparam logic [2:0] OP_CONV = 3'd0, OP_PART = 3'd1, OP_FULL = 3'd2, OP_WAKE = 3'd3;
  localparam logic [2:0] OP_INIT_N = 3'd4, OP_INIT_P = 3'd5, OP_INIT_F = 3'd6;
  localparam logic [1:0] M_NORM = 2'd0, M_PART = 2'd1, M_FULL = 2'd2, M_UNK = 2'd3;

  typedef enum logic [1:0] {S_IDLE, S_LOW, S_QUIET} state_t;

  state_t              st;
  logic [2:0]          op_q;
  logic [1:0]          frm;
  logic [4:0]          fe;
  logic [DW-1:0]       div_cnt;
  logic [QW-1:0]       q_cnt;
  logic [PW-1:0]       pu_cnt;
  logic [RES_BITS-1:0] sh;
  logic                legal;
  logic [4:0]          flen;
  logic [1:0]          last_frm;
  logic                div_hit;

  function automatic logic [1:0] mode_after(input logic [4:0] edges, input logic [1:0] m);
    if (edges >= 5'd10)       return M_NORM;
    else if (m == M_NORM)     return (edges >= 5'd2) ? M_PART : M_NORM;
    else                      return M_FULL;
  endfunction

  always_comb begin
    case (cmd_op)
      OP_CONV, OP_PART:                 legal = (pwr_mode == M_NORM);
      OP_FULL:                          legal = (pwr_mode == M_PART);
      OP_WAKE:                          legal = (pwr_mode != M_NORM);
      OP_INIT_N, OP_INIT_P, OP_INIT_F:  legal = 1'b1;
      default:                          legal = 1'b0;
    endcase
  end

  always_comb begin
    case (op_q)
      OP_PART:   flen = 5'(PART_EDGES);
      OP_FULL:   flen = 5'(FULL_EDGES);
      OP_INIT_N, OP_INIT_P, OP_INIT_F:
        flen = (frm == 2'd0) ? FRAME_LEN : (frm == 2'd1) ? 5'(PART_EDGES) : 5'(FULL_EDGES);
      default:   flen = FRAME_LEN;
    endcase
  end

  assign last_frm = (op_q == OP_INIT_P) ? 2'd1 : (op_q == OP_INIT_F) ? 2'd2 : 2'd0;
  assign div_hit  = (div_cnt == DW'(CLK_DIV - 1));
  assign busy     = (st != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      op_q <= OP_CONV;
      frm <= 2'd0;
      fe <= 5'd0;
      div_cnt <= '0;
      q_cnt <= '0;
      pu_cnt <= '0;
      sh <= '0;
      cs_n <= 1'b1;
      sclk <= 1'b1;
      result <= '0;
      result_valid <= 1'b0;
      pwr_mode <= M_UNK;
    end else begin
      result_valid <= 1'b0;
      if (pu_cnt != '0) pu_cnt <= pu_cnt - 1'b1;
      case (st)
        S_IDLE: begin
          if (cmd_valid && legal) begin
            op_q <= cmd_op;
            frm <= 2'd0;
            fe <= 5'd0;
            div_cnt <= '0;
            cs_n <= 1'b0;
            st <= S_LOW;
            if (cmd_op == OP_WAKE && pwr_mode == M_FULL) pu_cnt <= PW'(PWRUP_CLKS);
          end
        end
        S_LOW: begin
          if (!div_hit) begin
            div_cnt <= div_cnt + 1'b1;
          end else begin
            div_cnt <= '0;
            if (sclk) begin
              sclk <= 1'b0;
              fe <= fe + 5'd1;
            end else if (fe == flen) begin
              cs_n <= 1'b1;
              sclk <= 1'b1;
              pwr_mode <= mode_after(flen, pwr_mode);
              q_cnt <= '0;
              st <= S_QUIET;
              if (op_q == OP_CONV) begin
                result <= sh;
                result_valid <= 1'b1;
              end
            end else begin
              sclk <= 1'b1;
              if (fe >= 5'd2 && fe <= 5'(RES_BITS + 1)) sh <= {sh[RES_BITS-2:0], sdata};
            end
          end
        end
        default: begin
          if (q_cnt != QW'(QUIET_CLKS - 1)) begin
            q_cnt <= q_cnt + 1'b1;
          end else if (pu_cnt == '0) begin
            if (frm != last_frm) begin
              frm <= frm + 2'd1;
              fe <= 5'd0;
              div_cnt <= '0;
              cs_n <= 1'b0;
              st <= S_LOW;
            end else begin
              st <= S_IDLE;
            end
          end
        end
      endcase
    end
  end

  AST_SCLK_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> sclk); // R3
  AST_VALID_AT_CS_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |-> (cs_n && !$past(cs_n))); // R2
  AST_RESULT_ONLY_IN_NORMAL: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |-> ($past(pwr_mode) == M_NORM)); // R10
  AST_MODE_MOVES_AT_CS_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_mode != $past(pwr_mode)) |-> (cs_n && !$past(cs_n))); // R4
  AST_FULL_ONLY_FROM_PARTIAL: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_mode == M_FULL && $past(pwr_mode) != M_FULL) |-> ($past(pwr_mode) == M_PART)); // R5
  AST_BUSY_WHILE_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> busy); // R8
endmodule

// File: tb/adc_pwr_host_tb.sv
module adc_model #(parameter int RES = 12) (
  input  logic           cs_n,
  input  logic           sclk,
  input  logic [RES-1:0] value,
  output logic           sdata,
  output logic [4:0]     falls,
  output logic [1:0]     mode
);
  logic [15:0] frame;
  logic        started;
  initial begin
    sdata = 1'b0; falls = 5'd0; mode = 2'd3; started = 1'b0; frame = 16'd0;
  end
  always @(negedge cs_n) begin
    frame = {2'b00, value, {(14-RES){1'b0}}};
    falls = 5'd0;
    started = 1'b1;
    sdata = frame[15];
  end
  always @(negedge sclk) if (!cs_n) begin
    falls = falls + 5'd1;
    sdata = (falls < 5'd16) ? frame[15 - falls] : 1'b0;
  end
  always @(posedge cs_n) if (started) begin
    if (falls >= 5'd10)      mode = 2'd0;
    else if (mode == 2'd0)   mode = (falls >= 5'd2) ? 2'd1 : 2'd0;
    else                     mode = 2'd2;
  end
endmodule

module adc_pwr_host_tb;
  localparam int DIV = 4, PART = 4, FULLE = 2, QUIET = 8, PWRUP = 200;

  logic clk = 1'b0, rst_n = 1'b0, cmd_valid = 1'b0;
  logic [2:0] cmd_op = 3'd7;
  logic busy, cs_n, sclk, sdata, rv, busy10, cs10_n, sclk10, sdata10, rv10;
  logic [11:0] result, val12 = 12'd0;
  logic [9:0]  result10, val10 = 10'd0;
  logic [1:0]  pwr_mode, pwr_mode10, mdl_mode, mdl_mode10;
  logic [4:0]  mdl_falls, mdl_falls10;

  int n_chk = 0, n_fail = 0, cyc = 0;
  int rv_cnt = 0, rv10_cnt = 0, fall_cnt = 0, quiet_bad = 0, sclk_bad = 0, run = 0, hi_len = 0;
  logic [11:0] res_cap = 0;
  logic [9:0]  res10_cap = 0;
  logic prev_cs = 1'b1, prev_sclk = 1'b1;
  logic [1:0] bmode = 2'd3;

  always #2.5 clk = ~clk;

  adc_pwr_host #(.RES_BITS(12), .CLK_DIV(DIV), .PART_EDGES(PART), .FULL_EDGES(FULLE),
    .QUIET_CLKS(QUIET), .PWRUP_CLKS(PWRUP)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .busy(busy),
    .cs_n(cs_n), .sclk(sclk), .sdata(sdata), .result(result), .result_valid(rv),
    .pwr_mode(pwr_mode));
  adc_model #(.RES(12)) u_mdl (.cs_n(cs_n), .sclk(sclk), .value(val12), .sdata(sdata),
    .falls(mdl_falls), .mode(mdl_mode));

  adc_pwr_host #(.RES_BITS(10), .CLK_DIV(DIV), .PART_EDGES(PART), .FULL_EDGES(FULLE),
    .QUIET_CLKS(QUIET), .PWRUP_CLKS(PWRUP)) u_dut10 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .busy(busy10),
    .cs_n(cs10_n), .sclk(sclk10), .sdata(sdata10), .result(result10), .result_valid(rv10),
    .pwr_mode(pwr_mode10));
  adc_model #(.RES(10)) u_mdl10 (.cs_n(cs10_n), .sclk(sclk10), .value(val10), .sdata(sdata10),
    .falls(mdl_falls10), .mode(mdl_mode10));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  always @(negedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      chk(1'b0, "watchdog", cyc, 0);
      finish_run();
    end
    if (rst_n) begin
      if (rv) begin rv_cnt++; res_cap = result; end
      if (rv10) begin rv10_cnt++; res10_cap = result10; end
      if (cs_n && !sclk) sclk_bad++;
      if (!prev_cs) begin
        if (cs_n || sclk != prev_sclk) begin
          if (run != DIV) sclk_bad++;
          run = 1;
        end else run++;
      end else run = 1;
      if (prev_cs && !cs_n) begin
        fall_cnt++;
        if (hi_len < QUIET) quiet_bad++;
        hi_len = 0;
      end
      if (cs_n) hi_len++;
    end
    prev_cs = cs_n;
    prev_sclk = sclk;
  end

  function automatic bit f_accept(input logic [2:0] op, input logic [1:0] m);
    case (op)
      3'd0, 3'd1: return m == 2'd0;
      3'd2:       return m == 2'd1;
      3'd3:       return m != 2'd0;
      3'd4, 3'd5, 3'd6: return 1'b1;
      default:    return 1'b0;
    endcase
  endfunction
  function automatic int f_frames(input logic [2:0] op);
    return (op == 3'd5) ? 2 : (op == 3'd6) ? 3 : 1;
  endfunction
  function automatic int f_edges(input logic [2:0] op);
    case (op)
      3'd1, 3'd5: return PART;
      3'd2, 3'd6: return FULLE;
      default:    return 16;
    endcase
  endfunction
  function automatic logic [1:0] f_mode(input logic [2:0] op);
    case (op)
      3'd1, 3'd5: return 2'd1;
      3'd2, 3'd6: return 2'd2;
      default:    return 2'd0;
    endcase
  endfunction
  function automatic string f_req(input logic [2:0] op);
    case (op)
      3'd0: return "R2";
      3'd1: return "R4";
      3'd2: return "R5";
      3'd3: return "R6";
      3'd7: return "R10";
      default: return "R9";
    endcase
  endfunction

  task automatic run_cmd(input logic [2:0] op, input logic [11:0] v, input logic [9:0] v10, input bit poke);
    bit acc;
    int t0;
    int k;
    string rq;
    acc = f_accept(op, bmode);
    rq = acc ? f_req(op) : "R10";
    if (op == 3'd2 && !acc) rq = "R5";
    val12 = v; val10 = v10;
    rv_cnt = 0; rv10_cnt = 0; fall_cnt = 0;
    @(negedge clk); cmd_valid = 1'b1; cmd_op = op;
    @(negedge clk); cmd_valid = 1'b0; cmd_op = 3'd7; t0 = cyc;
    if (!acc) begin
      repeat (6) @(negedge clk);
      chk(!busy && fall_cnt == 0, rq, fall_cnt, 0);
      chk(pwr_mode == bmode, rq, pwr_mode, bmode);
    end else begin
      chk(busy, rq, busy, 1);
      k = 0;
      while (busy && k < 5000) begin
        @(negedge clk);
        k++;
        if (poke && k == 20) begin cmd_valid = 1'b1; cmd_op = 3'd1; end
        if (poke && k == 21) begin cmd_valid = 1'b0; cmd_op = 3'd7; end
      end
      if (busy) chk(1'b0, "watchdog", k, 5000);
      chk(fall_cnt == f_frames(op), poke ? "R10" : rq, fall_cnt, f_frames(op));
      chk(int'(mdl_falls) == f_edges(op), rq, mdl_falls, f_edges(op));
      chk(pwr_mode == f_mode(op) && mdl_mode == f_mode(op), rq, pwr_mode, f_mode(op));
      chk(pwr_mode10 == f_mode(op), "R11", pwr_mode10, f_mode(op));
      chk(rv_cnt == ((op == 3'd0) ? 1 : 0), rq, rv_cnt, (op == 3'd0) ? 1 : 0);
      if (op == 3'd0) begin
        chk(res_cap == v, "R2", res_cap, v);
        chk(rv10_cnt == 1 && res10_cap == v10, "R11", res10_cap, v10);
      end
      if (op == 3'd3 && bmode == 2'd2) chk(cyc - t0 >= PWRUP, "R7", cyc - t0, PWRUP);
      chk(quiet_bad == 0, "R8", quiet_bad, 0);
      chk(sclk_bad == 0, "R3", sclk_bad, 0);
      bmode = f_mode(op);
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (10) @(negedge clk);
    chk(cs_n && sclk && !busy && !rv && pwr_mode == 2'd3, "R1", {cs_n, sclk, busy, rv, pwr_mode}, 6'b110011);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(cs_n && sclk && !busy && pwr_mode == 2'd3, "R1", pwr_mode, 3);
    run_cmd(3'd0, 12'h123, 10'h1, 1'b0);
    run_cmd(3'd2, 12'h0, 10'h0, 1'b0);
    run_cmd(3'd4, 12'h0, 10'h0, 1'b0);
    run_cmd(3'd2, 12'h0, 10'h0, 1'b0);
    run_cmd(3'd7, 12'h0, 10'h0, 1'b0);
    run_cmd(3'd0, 12'hFFF, 10'h3FF, 1'b0);
    run_cmd(3'd0, 12'h000, 10'h000, 1'b0);
    run_cmd(3'd0, 12'hA5A, 10'h2A5, 1'b1);
    run_cmd(3'd1, 12'h0, 10'h0, 1'b0);
    run_cmd(3'd0, 12'h0, 10'h0, 1'b0);
    run_cmd(3'd2, 12'h0, 10'h0, 1'b0);
    run_cmd(3'd3, 12'h0, 10'h0, 1'b0);
    run_cmd(3'd0, 12'h801, 10'h201, 1'b0);
    run_cmd(3'd6, 12'h0, 10'h0, 1'b0);
    run_cmd(3'd3, 12'h0, 10'h0, 1'b0);
    run_cmd(3'd5, 12'h0, 10'h0, 1'b0);
    run_cmd(3'd3, 12'h0, 10'h0, 1'b0);
    for (int i = 0; i < 200; i++) begin
      logic [2:0] op;
      op = ($urandom % 3 == 0) ? 3'($urandom % 8) : 3'd0;
      run_cmd(op, 12'($urandom), 10'($urandom), ($urandom % 10) == 0);
    end
    finish_run();
  end
endmodule